// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block steers a single-bus processor datapath. A step counter advances once per clock through the control steps of an instruction. A decoder expands the count into one-hot step terms T1..T7. A second decoder sorts the opcode field of the instruction register into instruction classes. A combinational encoder forms every control line as its own sum of products of step terms and instruction-class terms.

The first three steps fetch the instruction and increment the program counter, and they are the same for every opcode. The later steps run a register add (R1 gets R1+R3), a register-indirect add (R1 gets R1 plus the memory word addressed by R3), or a relative branch (PC gets PC plus the displacement field of the instruction). The final step of each sequence raises the end line, and the counter goes back to T1 on the next clock. An opcode outside the three classes raises the end line alone in T4, so the unit returns straight to fetch.

Top module: `hw_ctrl_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the step counter goes to T1. After that edge `ctrl_o` carries the T1 fetch word.
- R2: Bit positions of `ctrl_o`, counted from bit 0: pc_out, pc_in, mar_in, mem_rd, clr_y, carry_in, alu_add, z_in, z_out, mbr_out, ir_in, r1_out, r1_in, r3_out, y_in, disp_out, step_end. In T1 exactly pc_out, mar_in, mem_rd, clr_y, carry_in, alu_add and z_in are high.
- R3: In T2 exactly z_out and pc_in are high.
- R4: In T3 exactly mbr_out and ir_in are high.
- R5: With opcode 4'h1 (register add), exactly these lines are high in each step: T4 r1_out and y_in; T5 r3_out, alu_add and z_in; T6 z_out, r1_in and step_end.
- R6: With opcode 4'h2 (register-indirect add), exactly these lines are high in each step: T4 r3_out, mar_in and mem_rd; T5 r1_out and y_in; T6 mbr_out, alu_add and z_in; T7 z_out, r1_in and step_end.
- R7: With opcode 4'h3 (relative branch), exactly these lines are high in each step: T4 pc_out and y_in; T5 disp_out, alu_add and z_in; T6 z_out, pc_in and step_end.
- R8: When step_end is high, the next clock returns the counter to T1. When it is low, the counter advances by exactly one step.
- R9: Any opcode other than 4'h1, 4'h2 or 4'h3 gives a T4 word in which step_end is the only high line. The cycle after it is T1.
- R10: In every step at most one of the bus drivers (pc_out, z_out, mbr_out, r1_out, r3_out, disp_out) is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; one control step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_opcode | input | OPC_W (4) | Opcode field of the instruction register |
| ctrl_o | output | 17 | Control-signal vector, bit order as in R2 |

## Verification
The case hardest to reach from the ports is a reset that arrives in the middle of an instruction. A sequence that ends only after a long run of steps, such as T7 of the indirect add, has to be cut short. The counter must then restart at fetch and not resume where it stopped. The bench reaches this with directed runs that pull `rst_n` low partway through the indirect add and the branch. After that comes a long random run of opcodes, weighted toward the three legal classes and mixed with undefined codes. This run puts each instruction after every other one, so the step_end return and the early return on an undefined code are exercised between every pair of sequences.

// File: rtl/hw_ctrl_pkg.sv
// Package: shared control-line indices and the instruction-class record.
// Assumes: control vector bit order is fixed by the line index enum below.
package hw_ctrl_pkg;

    typedef enum int unsigned {
        SIG_PC_OUT   = 0,
        SIG_PC_IN    = 1,
        SIG_MAR_IN   = 2,
        SIG_MEM_RD   = 3,
        SIG_CLR_Y    = 4,
        SIG_CARRY_IN = 5,
        SIG_ALU_ADD  = 6,
        SIG_Z_IN     = 7,
        SIG_Z_OUT    = 8,
        SIG_MBR_OUT  = 9,
        SIG_IR_IN    = 10,
        SIG_R1_OUT   = 11,
        SIG_R1_IN    = 12,
        SIG_R3_OUT   = 13,
        SIG_Y_IN     = 14,
        SIG_DISP_OUT = 15,
        SIG_END      = 16
    } ctl_sig_e;

    localparam int NUM_SIG = 17;

    typedef struct packed {
        logic add_reg;
        logic add_ind;
        logic branch;
        logic illegal;
    } instr_cls_t;

endpackage

// File: rtl/ctrl_step_counter.sv
// Module: binary control-step counter.
// Does: holds the current step index, restarts at zero on reset or end,
// and otherwise increments, saturating at the last step.
// Assumes: synchronous active-low reset; end_i is sampled at the clock edge.
module ctrl_step_counter #(
    parameter int N_STEPS = 7,
    localparam int CNT_W = $clog2(N_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_STEPS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance, restart or hold the step index once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (end_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ctrl_step_decoder.sv
// Module: one-hot step decoder.
// Does: expands the binary step index into T1..Tn terms (bit 0 = T1).
// Assumes: index never exceeds N_STEPS-1.
module ctrl_step_decoder #(
    parameter int N_STEPS = 7,
    localparam int CNT_W = $clog2(N_STEPS)
) (
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [N_STEPS-1:0] step_oh_o
);

    for (genvar i = 0; i < N_STEPS; i++) begin : g_term
        // One comparator per step term.
        assign step_oh_o[i] = (cnt_i == CNT_W'(i));
    end

endmodule

// File: rtl/ctrl_instr_decoder.sv
// Module: opcode classifier.
// Does: maps the IR opcode field onto one class flag; codes that match no
// supported instruction raise the illegal flag.
// Assumes: exactly one class flag is high for any opcode value.
module ctrl_instr_decoder
    import hw_ctrl_pkg::*;
#(
    parameter int               OPC_W    = 4,
    parameter logic [OPC_W-1:0] OP_ADD_R = 4'h1,
    parameter logic [OPC_W-1:0] OP_ADD_I = 4'h2,
    parameter logic [OPC_W-1:0] OP_BR    = 4'h3
) (
    input  logic [OPC_W-1:0] opcode_i,
    output instr_cls_t       cls_o
);

    // Classify the current opcode.
    always_comb begin
        cls_o         = '0;
        cls_o.add_reg = (opcode_i == OP_ADD_R);
        cls_o.add_ind = (opcode_i == OP_ADD_I);
        cls_o.branch  = (opcode_i == OP_BR);
        cls_o.illegal = !(cls_o.add_reg || cls_o.add_ind || cls_o.branch);
    end

endmodule

// File: rtl/ctrl_signal_encoder.sv
// Module: combinational control-line generator.
// Does: forms each control line as a sum of products of one-hot step terms
// and instruction-class terms.
// Assumes: step_oh_i is one-hot with bit 0 = T1; at least 7 steps exist.
module ctrl_signal_encoder
    import hw_ctrl_pkg::*;
#(
    parameter int N_STEPS = 7
) (
    input  logic [N_STEPS-1:0] step_oh_i,
    input  instr_cls_t         cls_i,
    output logic [NUM_SIG-1:0] ctrl_o
);

    logic t1, t2, t3, t4, t5, t6, t7;
    logic ar, ai, br, bad;

    assign t1  = step_oh_i[0];
    assign t2  = step_oh_i[1];
    assign t3  = step_oh_i[2];
    assign t4  = step_oh_i[3];
    assign t5  = step_oh_i[4];
    assign t6  = step_oh_i[5];
    assign t7  = step_oh_i[6];
    assign ar  = cls_i.add_reg;
    assign ai  = cls_i.add_ind;
    assign br  = cls_i.branch;
    assign bad = cls_i.illegal;

    // One product sum per control line.
    always_comb begin
        ctrl_o               = '0;
        ctrl_o[SIG_PC_OUT]   = t1 | (t4 & br);
        ctrl_o[SIG_PC_IN]    = t2 | (t6 & br);
        ctrl_o[SIG_MAR_IN]   = t1 | (t4 & ai);
        ctrl_o[SIG_MEM_RD]   = t1 | (t4 & ai);
        ctrl_o[SIG_CLR_Y]    = t1;
        ctrl_o[SIG_CARRY_IN] = t1;
        ctrl_o[SIG_ALU_ADD]  = t1 | (t5 & (ar | br)) | (t6 & ai);
        ctrl_o[SIG_Z_IN]     = t1 | (t5 & (ar | br)) | (t6 & ai);
        ctrl_o[SIG_Z_OUT]    = t2 | (t6 & (ar | br)) | (t7 & ai);
        ctrl_o[SIG_MBR_OUT]  = t3 | (t6 & ai);
        ctrl_o[SIG_IR_IN]    = t3;
        ctrl_o[SIG_R1_OUT]   = (t4 & ar) | (t5 & ai);
        ctrl_o[SIG_R1_IN]    = (t6 & ar) | (t7 & ai);
        ctrl_o[SIG_R3_OUT]   = (t5 & ar) | (t4 & ai);
        ctrl_o[SIG_Y_IN]     = (t4 & (ar | br)) | (t5 & ai);
        ctrl_o[SIG_DISP_OUT] = t5 & br;
        ctrl_o[SIG_END]      = (t6 & (ar | br)) | (t7 & ai) | (t4 & bad);
    end

endmodule

// File: rtl/hw_ctrl_unit.sv
// Module: hardwired control unit (top).
// Does: sequences fetch and execute steps for register add, register-
// indirect add and relative branch, producing the control-line vector.
// Assumes: ir_opcode holds the loaded instruction from T4 onward;
// synchronous active-low reset.
module hw_ctrl_unit
    import hw_ctrl_pkg::*;
#(
    parameter int               N_STEPS  = 7,
    parameter int               OPC_W    = 4,
    parameter logic [OPC_W-1:0] OP_ADD_R = 4'h1,
    parameter logic [OPC_W-1:0] OP_ADD_I = 4'h2,
    parameter logic [OPC_W-1:0] OP_BR    = 4'h3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPC_W-1:0]   ir_opcode,
    output logic [NUM_SIG-1:0] ctrl_o
);

    localparam int CNT_W = $clog2(N_STEPS);

    logic [CNT_W-1:0]   step_cnt;
    logic [N_STEPS-1:0] step_oh;
    instr_cls_t         instr_cls;
    logic [NUM_SIG-1:0] ctrl_vec;

    ctrl_step_counter #(.N_STEPS(N_STEPS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .end_i (ctrl_vec[SIG_END]),
        .cnt_o (step_cnt)
    );

    ctrl_step_decoder #(.N_STEPS(N_STEPS)) u_tdec (
        .cnt_i     (step_cnt),
        .step_oh_o (step_oh)
    );

    ctrl_instr_decoder #(
        .OPC_W    (OPC_W),
        .OP_ADD_R (OP_ADD_R),
        .OP_ADD_I (OP_ADD_I),
        .OP_BR    (OP_BR)
    ) u_idec (
        .opcode_i (ir_opcode),
        .cls_o    (instr_cls)
    );

    ctrl_signal_encoder #(.N_STEPS(N_STEPS)) u_enc (
        .step_oh_i (step_oh),
        .cls_i     (instr_cls),
        .ctrl_o    (ctrl_vec)
    );

    assign ctrl_o = ctrl_vec;

endmodule

// File: rtl/hw_ctrl_unit_chk.sv
// Module: property checker for hw_ctrl_unit, attached by bind.
// Does: checks step sequencing, the end return, the illegal-opcode exit,
// and bus-driver exclusivity.
// Assumes: bound inside hw_ctrl_unit with its internal step terms.
module hw_ctrl_unit_chk
    import hw_ctrl_pkg::*;
#(
    parameter int N_STEPS = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_STEPS-1:0] step_oh,
    input instr_cls_t         cls,
    input logic [NUM_SIG-1:0] ctrl
);

    logic [5:0] bus_drv;
    assign bus_drv = {ctrl[SIG_PC_OUT], ctrl[SIG_Z_OUT], ctrl[SIG_MBR_OUT],
                      ctrl[SIG_R1_OUT], ctrl[SIG_R3_OUT], ctrl[SIG_DISP_OUT]};

    // Reset lands on T1.
    assert_reset_t1_R1: assert property (@(posedge clk)
        !rst_n |=> step_oh == N_STEPS'(1));

    // Step terms stay one-hot.
    assert_step_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_oh) == 1);

    // End returns to T1.
    assert_end_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[SIG_END] |=> step_oh[0]);

    // Without end the step advances by one.
    assert_step_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[SIG_END] |=> step_oh == ($past(step_oh) << 1));

    // Illegal opcode in T4 yields only the end line.
    assert_illegal_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_oh[3] && cls.illegal) |-> ctrl == (NUM_SIG'(1) << SIG_END));

    // Single bus driver per step.
    assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_drv) <= 1);

    // A memory read always has its address latched in the same step.
    assert_read_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[SIG_MEM_RD] |-> ctrl[SIG_MAR_IN]);

endmodule

bind hw_ctrl_unit hw_ctrl_unit_chk #(.N_STEPS(N_STEPS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_oh (step_oh),
    .cls     (instr_cls),
    .ctrl    (ctrl_vec)
);

// File: tb/hw_ctrl_unit_test.sv
`timescale 1ns/1ps
module hw_ctrl_unit_test;

    localparam int NS = 17;
    // Bit positions from R2.
    localparam int B_PCO = 0, B_PCI = 1, B_MAR = 2, B_RD = 3, B_CLY = 4,
                   B_CIN = 5, B_ADD = 6, B_ZIN = 7, B_ZO = 8, B_MBO = 9,
                   B_IRI = 10, B_R1O = 11, B_R1I = 12, B_R3O = 13, B_YIN = 14,
                   B_DSP = 15, B_END = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    ir_opcode = 4'h0;
    logic [NS-1:0] ctrl_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    hw_ctrl_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_opcode (ir_opcode),
        .ctrl_o    (ctrl_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic [NS-1:0] bits(input int a, input int b = -1,
                                           input int c = -1, input int d = -1);
        logic [NS-1:0] w = '0;
        w[a] = 1'b1;
        if (b >= 0) w[b] = 1'b1;
        if (c >= 0) w[c] = 1'b1;
        if (d >= 0) w[d] = 1'b1;
        return w;
    endfunction

    // Expected word for opcode and step (1-based), from R2-R7 and R9.
    function automatic logic [NS-1:0] exp_word(input logic [3:0] opc, input int s);
        case (s)
            1: return bits(B_PCO, B_MAR, B_RD, B_CLY) | bits(B_CIN, B_ADD, B_ZIN);
            2: return bits(B_ZO, B_PCI);
            3: return bits(B_MBO, B_IRI);
            default: ;
        endcase
        case (opc)
            4'h1: case (s)
                4: return bits(B_R1O, B_YIN);
                5: return bits(B_R3O, B_ADD, B_ZIN);
                6: return bits(B_ZO, B_R1I, B_END);
                default: return 'x;
            endcase
            4'h2: case (s)
                4: return bits(B_R3O, B_MAR, B_RD);
                5: return bits(B_R1O, B_YIN);
                6: return bits(B_MBO, B_ADD, B_ZIN);
                7: return bits(B_ZO, B_R1I, B_END);
                default: return 'x;
            endcase
            4'h3: case (s)
                4: return bits(B_PCO, B_YIN);
                5: return bits(B_DSP, B_ADD, B_ZIN);
                6: return bits(B_ZO, B_PCI, B_END);
                default: return 'x;
            endcase
            default: return (s == 4) ? bits(B_END) : 'x;
        endcase
    endfunction

    function automatic int seq_len(input logic [3:0] opc);
        case (opc)
            4'h1, 4'h3: return 6;
            4'h2:       return 7;
            default:    return 4;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] opc, input int s);
        if (s == 1) return "R2";
        if (s == 2) return "R3";
        if (s == 3) return "R4";
        case (opc)
            4'h1: return "R5";
            4'h2: return "R6";
            4'h3: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [NS-1:0] act,
                         input logic [NS-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ctrl_o actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R10: bus exclusivity, checked on every sampled word.
    task automatic check_bus(input logic [NS-1:0] w);
        int n = int'(w[B_PCO]) + int'(w[B_ZO]) + int'(w[B_MBO]) +
                int'(w[B_R1O]) + int'(w[B_R3O]) + int'(w[B_DSP]);
        n_cmp++;
        if (n > 1) begin
            n_bad++;
            $display("FAIL R10: bus drivers actual=%0d expected<=1", n);
        end
    endtask

    // Run steps 1..upto of an instruction; called at a negedge in T1.
    task automatic run_instr(input logic [3:0] opc, input int upto);
        ir_opcode = opc;
        for (int s = 1; s <= upto; s++) begin
            #1;
            check(req_of(opc, s), ctrl_o, exp_word(opc, s));
            check_bus(ctrl_o);
            @(negedge clk);
        end
    endtask

    task automatic mid_reset(input logic [3:0] opc, input int upto);
        run_instr(opc, upto);
        rst_n = 1'b0;
        @(negedge clk);
        #1 check("R1", ctrl_o, exp_word(opc, 1));
        rst_n = 1'b1;
        @(negedge clk);
        // Counter advanced from T1 to T2 after release (R8).
        #1 check("R8", ctrl_o, exp_word(opc, 2));
        // Finish this instruction from step 3 onward.
        for (int s = 3; s <= seq_len(opc); s++) begin
            @(negedge clk);
            #1 check(req_of(opc, s), ctrl_o, exp_word(opc, s));
        end
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: cycles actual=%0d expected<=100000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int unsigned seed_tmp;
        seed_tmp = $urandom(32'd1234);
        // R1: reset state.
        @(negedge clk);
        @(negedge clk);
        #1 check("R1", ctrl_o, exp_word(4'h0, 1));
        rst_n = 1'b1;
        @(negedge clk);
        // Sequence after reset release starts at T2; realign by finishing
        // an undefined instruction (T2..T4) then directed runs.
        #1 check("R3", ctrl_o, exp_word(4'hF, 2));
        @(negedge clk);
        #1 check("R4", ctrl_o, exp_word(4'hF, 3));
        @(negedge clk);
        #1 check("R9", ctrl_o, exp_word(4'hF, 4));
        @(negedge clk);
        // R8/R9: back at T1 after the early end.
        #1 check("R9", ctrl_o, exp_word(4'hF, 1));

        // Directed: each class back to back (R5, R6, R7, R8).
        run_instr(4'h1, 6);
        run_instr(4'h2, 7);
        run_instr(4'h3, 6);
        run_instr(4'h0, 4);
        run_instr(4'h2, 7);
        run_instr(4'h1, 6);

        // Directed: reset in the middle of long sequences (R1).
        mid_reset(4'h2, 5);
        mid_reset(4'h3, 4);

        // Random mix of opcodes.
        for (int k = 0; k < 60; k++) begin
            logic [3:0] opc;
            int unsigned r = $urandom % 8;
            if (r < 2)      opc = 4'h1;
            else if (r < 4) opc = 4'h2;
            else if (r < 6) opc = 4'h3;
            else            opc = 4'($urandom % 16);
            run_instr(opc, seq_len(opc));
        end
        // R8: final return to fetch.
        #1 check("R8", ctrl_o, exp_word(4'h0, 1));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule